// File: doc/BRIEF.md
# Pipelined Burst SRAM Front End

This block is a small clocked memory with a processor-style burst interface. An access begins when one of two active-low address strobes loads a new address. One strobe is the processor strobe and the other is the controller strobe. At that same edge the three chip-enable inputs are sampled, and they decide whether the device is selected. The two least-significant address bits go into a 2-bit burst counter. On later cycles the active-low advance input steps this counter, so a burst of four beats can run without a new address.

On a selected cycle the array is either written or read. A write can cover every lane at once (global write) or only the lanes picked by per-lane selects (byte write). A read puts its data on a registered output stage one clock after the address is registered, and flags it with a valid bit. The data bus is modelled as separate write and read buses with a drive-enable flag. Tri-state pads, power and sleep behaviour are not modelled. The drive-enable flag follows an asynchronous active-low output enable. It stays low for the data slot of the first read that comes after a deselected state.

Top module: `sbsram_front`

## Requirements
- R1: While reset is held, and after it is released until an access is made, the device is deselected: `rvalid_o` and `drive_en_o` are 0.
- R2: A new address is loaded when the controller strobe is low, or when the processor strobe is low and `ce1_n_i` is low. The address low two bits load the burst counter. A low processor strobe with `ce1_n_i` high and the controller strobe high loads nothing, and the previous access state carries on.
- R3: If both strobes are low, the processor strobe wins. A cycle started by the processor strobe is always a read, and the write inputs are ignored in that cycle.
- R4: The chip enables (`ce1_n_i` low, `ce2_i` high, `ce3_n_i` low) are evaluated only on a load cycle. On other cycles the selected or deselected state is held, whatever the chip enables do.
- R5: On a selected cycle with no load and `adv_n_i` low, the burst counter increments modulo 4 and the upper address bits stay the same. With `adv_n_i` high, the address is held.
- R6: A low `gw_n_i` on a selected, non-processor-started cycle writes all lanes, whatever `bwe_n_i` and `bsel_n_i` are.
- R7: With `gw_n_i` high, a lane is written only when `bwe_n_i` is low and that lane's bit of `bsel_n_i` is low. Lane k is data bits [8k+7:8k]. With `bwe_n_i` high, nothing is written.
- R8: A selected cycle that writes no lane is a read. The data at its address appears on `rdata_o` with `rvalid_o` high one clock after that address is registered. A write to the same address in the following cycle does not change this read data.
- R9: A deselected device writes nothing, and `rvalid_o` stays low for it.
- R10: `drive_en_o` is high only when `oe_n_i` is low and `rvalid_o` is high. It is held low for the data slot of the first read loaded directly after a deselected state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | AW | Word address |
| ads_proc_n_i | input | 1 | Processor address strobe, active low, higher priority |
| ads_ctrl_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| ce1_n_i | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| ce2_i | input | 1 | Chip enable 2, active high |
| ce3_n_i | input | 1 | Chip enable 3, active low |
| gw_n_i | input | 1 | Global write, active low |
| bwe_n_i | input | 1 | Byte-write enable, active low |
| bsel_n_i | input | LANES | Per-lane byte selects, active low |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Registered read data |
| rvalid_o | output | 1 | Read data valid |
| drive_en_o | output | 1 | Output drive enable for the read bus |

## Verification
The bench builds the block with its default parameters: a 6-bit address (64 words) and four 8-bit lanes. With this depth, a global-write pass can initialise every word, so every read that follows has a known expected value. Four lanes allow mixed select patterns such as alternating lanes. The 4-bit upper address field leaves room for bursts that wrap inside many aligned groups during random traffic. Directed sequences cover these cases: strobe priority, a gated processor strobe, held selection while deselected, and the masked first read.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int unsigned CNT_W = 2;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sbs_op_e;
endpackage

// File: rtl/sbs_addr_ctrl.sv
module sbs_addr_ctrl
  import sbs_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          ads_proc_n_i,
  input  logic          ads_ctrl_n_i,
  input  logic          adv_n_i,
  input  logic          ce1_n_i,
  input  logic          ce2_i,
  input  logic          ce3_n_i,
  output logic [AW-1:0] eff_addr_o,
  output logic          sel_nxt_o,
  output logic          proc_start_o,
  output logic          load_o,
  output logic          sel_q_o
);
  localparam int unsigned UW = AW - CNT_W;

  logic [UW-1:0]    up_q, up_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sel_q, sel_d;
  logic             proc_start, load, ce_ok;

  always_comb begin
    proc_start = !ads_proc_n_i && !ce1_n_i;
    load       = proc_start || !ads_ctrl_n_i;
    ce_ok      = !ce1_n_i && ce2_i && !ce3_n_i;
    up_d       = up_q;
    cnt_d      = cnt_q;
    sel_d      = sel_q;
    if (load) begin
      up_d  = addr_i[AW-1:CNT_W];
      cnt_d = addr_i[CNT_W-1:0];
      sel_d = ce_ok;
    end else if (sel_q && !adv_n_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q  <= '0;
      cnt_q <= '0;
      sel_q <= 1'b0;
    end else begin
      up_q  <= up_d;
      cnt_q <= cnt_d;
      sel_q <= sel_d;
    end
  end

  assign eff_addr_o   = {up_d, cnt_d};
  assign sel_nxt_o    = sel_d;
  assign proc_start_o = proc_start;
  assign load_o       = load;
  assign sel_q_o      = sel_q;

  // R2: low bits of a loaded address land in the counter
  p_load_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(addr_i[CNT_W-1:0]));
  // R2: gated processor strobe alone loads nothing
  p_gated_proc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_proc_n_i && ce1_n_i && ads_ctrl_n_i) |=> $stable(up_q) && $stable(sel_q));
  // R4: selection only changes on a load
  p_sel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(sel_q));
  // R5: advance steps modulo 4, upper bits fixed
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && sel_q && !adv_n_i) |=> (cnt_q == $past(cnt_q) + 2'd1) && $stable(up_q));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv_n_i) |=> $stable(cnt_q) && $stable(up_q));
endmodule

// File: rtl/sbs_write_decode.sv
module sbs_write_decode
  import sbs_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic             sel_nxt_i,
  input  logic             proc_start_i,
  input  logic             gw_n_i,
  input  logic             bwe_n_i,
  input  logic [LANES-1:0] bsel_n_i,
  output logic [LANES-1:0] lane_we_o,
  output sbs_op_e          op_o
);
  always_comb begin
    lane_we_o = '0;
    op_o      = OP_IDLE;
    if (sel_nxt_i) begin
      if (!proc_start_i) begin
        if (!gw_n_i)       lane_we_o = '1;
        else if (!bwe_n_i) lane_we_o = ~bsel_n_i;
      end
      op_o = (lane_we_o != '0) ? OP_WRITE : OP_READ;
    end
  end
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int unsigned AW     = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        lane_we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    rd_req_i,
  input  logic                    first_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    valid_o,
  output logic                    first_o
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned DW    = LANES * LANE_W;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] cur_addr_q;
  logic          cur_rd_q, cur_first_q;
  logic [DW-1:0] rdata_q;
  logic          valid_q, first_q;

  always_ff @(posedge clk) begin
    for (int l = 0; l < int'(LANES); l++) begin
      if (lane_we_i[l]) mem[addr_i][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr_q  <= '0;
      cur_rd_q    <= 1'b0;
      cur_first_q <= 1'b0;
      valid_q     <= 1'b0;
      first_q     <= 1'b0;
    end else begin
      cur_addr_q  <= addr_i;
      cur_rd_q    <= rd_req_i;
      cur_first_q <= first_i;
      valid_q     <= cur_rd_q;
      first_q     <= cur_first_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (cur_rd_q) rdata_q <= mem[cur_addr_q];
  end

  assign rdata_o = rdata_q;
  assign valid_o = valid_q;
  assign first_o = first_q;
endmodule

// File: rtl/sbsram_front.sv
module sbsram_front
  import sbs_pkg::*;
#(
  parameter int unsigned AW     = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           addr_i,
  input  logic                    ads_proc_n_i,
  input  logic                    ads_ctrl_n_i,
  input  logic                    adv_n_i,
  input  logic                    ce1_n_i,
  input  logic                    ce2_i,
  input  logic                    ce3_n_i,
  input  logic                    gw_n_i,
  input  logic                    bwe_n_i,
  input  logic [LANES-1:0]        bsel_n_i,
  input  logic                    oe_n_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rvalid_o,
  output logic                    drive_en_o
);
  logic             rst_s1, rst_sync_n;
  logic [AW-1:0]    eff_addr;
  logic             sel_nxt, proc_start, load, sel_q;
  logic [LANES-1:0] lane_we;
  sbs_op_e          op;
  logic             first_rd, first_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  sbs_addr_ctrl #(.AW(AW)) u_addr (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .addr_i       (addr_i),
    .ads_proc_n_i (ads_proc_n_i),
    .ads_ctrl_n_i (ads_ctrl_n_i),
    .adv_n_i      (adv_n_i),
    .ce1_n_i      (ce1_n_i),
    .ce2_i        (ce2_i),
    .ce3_n_i      (ce3_n_i),
    .eff_addr_o   (eff_addr),
    .sel_nxt_o    (sel_nxt),
    .proc_start_o (proc_start),
    .load_o       (load),
    .sel_q_o      (sel_q)
  );

  sbs_write_decode #(.LANES(LANES)) u_dec (
    .sel_nxt_i    (sel_nxt),
    .proc_start_i (proc_start),
    .gw_n_i       (gw_n_i),
    .bwe_n_i      (bwe_n_i),
    .bsel_n_i     (bsel_n_i),
    .lane_we_o    (lane_we),
    .op_o         (op)
  );

  assign first_rd = load && (op == OP_READ) && !sel_q;

  sbs_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .lane_we_i (lane_we),
    .addr_i    (eff_addr),
    .wdata_i   (wdata_i),
    .rd_req_i  (op == OP_READ),
    .first_i   (first_rd),
    .rdata_o   (rdata_o),
    .valid_o   (rvalid_o),
    .first_o   (first_out)
  );

  assign drive_en_o = !oe_n_i && rvalid_o && !first_out;

  // R3: a processor-started cycle never writes
  p_proc_read_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    proc_start |-> lane_we == '0);
  // R6: global write covers all lanes on a selected controller cycle
  p_gw_all_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel_nxt && !proc_start && !gw_n_i) |-> &lane_we);
  // R7: no byte-write enable, no global write -> no lane
  p_bwe_gate_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (gw_n_i && bwe_n_i) |-> lane_we == '0);
  // R9: valid data only follows a selected cycle
  p_valid_sel_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rvalid_o |-> $past(sel_q));
  // R9: deselected cycles write nothing
  p_desel_nowr_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sel_nxt |-> lane_we == '0);
  // R10: drive only valid data under output enable
  p_drive_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    drive_en_o |-> rvalid_o && !oe_n_i);
endmodule

// File: tb/test_sbsram_front.sv
module test_sbsram_front;
  localparam int AW = 6, LANES = 4, LANE_W = 8;
  localparam int DW = LANES * LANE_W, DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic ads_p, ads_c, adv_n, ce1_n, ce2, ce3_n, gw_n, bwe_n, oe_n;
  logic [LANES-1:0] bsel_n;
  logic [DW-1:0] wdata, rdata;
  logic rvalid, drive_en;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  logic [DW-1:0] m_mem [DEPTH];
  logic [AW-3:0] m_up;
  logic [1:0] m_cnt;
  logic m_sel, m_cur_rd, m_cur_first, m_valid, m_first;
  logic [AW-1:0] m_cur_addr;
  logic [DW-1:0] m_rdata;

  always #5 clk = ~clk;

  sbsram_front #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) i_sbsram_front (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .ads_proc_n_i(ads_p), .ads_ctrl_n_i(ads_c),
    .adv_n_i(adv_n), .ce1_n_i(ce1_n), .ce2_i(ce2), .ce3_n_i(ce3_n), .gw_n_i(gw_n),
    .bwe_n_i(bwe_n), .bsel_n_i(bsel_n), .oe_n_i(oe_n), .wdata_i(wdata),
    .rdata_o(rdata), .rvalid_o(rvalid), .drive_en_o(drive_en));

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    addr = '0; ads_p = 1; ads_c = 1; adv_n = 1; ce1_n = 0; ce2 = 1; ce3_n = 0;
    gw_n = 1; bwe_n = 1; bsel_n = '1; oe_n = 0; wdata = '0;
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return 32'h9E3779B1 * (a + 1);
  endfunction

  task automatic step(input string tag);
    logic proc, load, ce_ok, nsel, rd, first;
    logic [AW-3:0] nup; logic [1:0] ncnt; logic [LANES-1:0] we;
    logic [DW-1:0] nrd; logic nval, nfirst;
    proc = !ads_p && !ce1_n; load = proc || !ads_c;
    ce_ok = !ce1_n && ce2 && !ce3_n;
    nsel = load ? ce_ok : m_sel; nup = m_up; ncnt = m_cnt;
    if (load) begin nup = addr[AW-1:2]; ncnt = addr[1:0]; end
    else if (m_sel && !adv_n) ncnt = m_cnt + 2'd1;
    we = '0;
    if (nsel && !proc) we = !gw_n ? '1 : (!bwe_n ? ~bsel_n : '0);
    rd = nsel && (we == '0);
    first = load && rd && !m_sel;
    nval = m_cur_rd; nfirst = m_cur_first;
    nrd = m_cur_rd ? m_mem[m_cur_addr] : m_rdata;
    @(posedge clk);
    for (int l = 0; l < LANES; l++)
      if (we[l]) m_mem[{nup, ncnt}][l*LANE_W +: LANE_W] = wdata[l*LANE_W +: LANE_W];
    m_up = nup; m_cnt = ncnt; m_sel = nsel; m_cur_rd = rd; m_cur_first = first;
    m_cur_addr = {nup, ncnt}; m_valid = nval; m_first = nfirst; m_rdata = nrd;
    @(negedge clk);
    chk({tag, " valid"}, {31'd0, rvalid}, {31'd0, m_valid});
    chk({tag, " drive"}, {31'd0, drive_en}, {31'd0, !oe_n && m_valid && !m_first});
    if (m_valid) chk({tag, " rdata"}, rdata, m_rdata);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle();
    m_up = '0; m_cnt = '0; m_sel = 0; m_cur_rd = 0; m_cur_first = 0;
    m_valid = 0; m_first = 0; m_cur_addr = '0; m_rdata = '0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {31'd0, rvalid}, 32'd0);
    chk("R1 reset drive", {31'd0, drive_en}, 32'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    step("R1");
    step("R1");

    // R6: fill whole array with global writes, noisy byte controls
    for (int a = 0; a < DEPTH; a++) begin
      idle(); ads_c = 0; addr = AW'(a); gw_n = 0; bwe_n = 1'($urandom);
      bsel_n = 4'($urandom); wdata = pat(a);
      step("R6");
    end
    // R2/R5/R8: processor burst from offset 2 wraps in its group
    idle(); ads_p = 0; addr = 6'h16; step("R2");
    idle(); adv_n = 0; step("R5"); step("R5"); step("R5");
    idle(); step("R5"); step("R8");
    // R9/R10: deselect, then first read masked
    idle(); ads_c = 0; ce2 = 0; step("R9");
    idle(); step("R9");
    idle(); ads_p = 0; addr = 6'h08; step("R10");
    idle(); adv_n = 0; step("R10"); step("R10"); step("R10");
    // R3: both strobes with global write: read, no write
    idle(); ads_p = 0; ads_c = 0; addr = 6'h20; gw_n = 0; wdata = 32'hDEADBEEF; step("R3");
    idle(); ads_c = 0; addr = 6'h20; step("R3"); step("R3"); step("R3");
    // R7: lanes 1 and 3 masked, then bwe high blocks writing
    idle(); ads_c = 0; addr = 6'h21; bwe_n = 0; bsel_n = 4'b1010; wdata = 32'hFFFFFFFF; step("R7");
    idle(); bwe_n = 1; bsel_n = 4'b0000; wdata = 32'h0; step("R7");
    idle(); ads_c = 0; addr = 6'h21; step("R7"); step("R7"); step("R7");
    // R4/R9: deselected, chip enables good but no load: no writes
    idle(); ads_c = 0; addr = 6'h30; ce3_n = 1; step("R4");
    idle(); gw_n = 0; wdata = 32'h12345678; adv_n = 0; step("R4"); step("R4");
    idle(); bwe_n = 0; bsel_n = 4'b0000; step("R9");
    idle(); ads_c = 0; addr = 6'h30; step("R9");
    idle(); adv_n = 0; step("R9"); step("R9"); step("R9");
    // R2: gated processor strobe does not reload
    idle(); ads_c = 0; addr = 6'h10; step("R2");
    idle(); ads_p = 0; ce1_n = 1; addr = 6'h3F; step("R2"); step("R2");
    idle(); step("R2");
    // R8: same-address write after read keeps read data
    idle(); ads_c = 0; addr = 6'h05; step("R8");
    idle(); gw_n = 0; wdata = 32'hCAFEF00D; step("R8");
    idle(); step("R8"); step("R8");

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      addr = AW'($urandom); ads_p = ($urandom % 6) != 0; ads_c = ($urandom % 5) != 0;
      adv_n = 1'($urandom); ce1_n = ($urandom % 8) == 0; ce2 = ($urandom % 8) != 0;
      ce3_n = ($urandom % 8) == 0; gw_n = ($urandom % 6) != 0; bwe_n = 1'($urandom);
      bsel_n = 4'($urandom); oe_n = ($urandom % 4) == 0; wdata = $urandom;
      step("R8 random");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule